// File: doc/BRIEF.md
# Guest Sleep and Wake Controller

This block lets a host processor supervise a legacy guest subsystem that can put itself to sleep. The host sees two 16-bit registers on a simple memory-mapped bus: a control/status register and a key-mask register. When the guest signals sleep, the controller records the event in a sticky status bit. If the host has enabled it, the controller also raises a level interrupt. At the same moment it copies the key-mask register to an output that feeds the input-scanning logic.

The host services the event with a single write. That write acknowledges the status bit and, in the same word, requests a wake. The controller then sends a one-cycle wake pulse to the guest. A wake command that is not paired with an acknowledge of a pending sleep status produces no pulse, so the guest is never released early.

Register map (word addresses on `bus_addr`): 0 is the control/status register and 1 is the key-mask register. Addresses 2 and 3 read as zero and ignore writes. Control register fields: bit 0 is the wake command (write-only), bit 1 is the sleep status (write 1 to clear), bit 15 is the interrupt enable, and bits 2 to 14 always read 0.

Top module: `guest_sleep_ctrl`

## Requirements
- R1: After reset, both registers read 0, `host_irq_o` is 0, `guest_wake_o` is 0 and `key_mask_o` is 0.
- R2: A 0-to-1 transition of `guest_sleep_i` sets control bit 1 on the following clock edge. Holding `guest_sleep_i` high sets it only once per sleep episode, so after an acknowledge it stays 0 until the input falls and rises again.
- R3: Control bit 15 holds the value last written to it and reads back. `host_irq_o` is high exactly while control bits 1 and 15 are both 1, and it falls in the cycle after either bit is cleared.
- R4: A control write with bit 1 set clears the sleep status. If bit 0 is not also set, no wake pulse is produced.
- R5: `guest_wake_o` is high for one cycle, in the cycle after a control write that sets both bit 0 and bit 1 while the sleep status is 1. No other control write (bit 0 alone, or bits 0 and 1 with no status pending) produces a pulse.
- R6: Reading the control register returns 0 in bit 0 and in bits 2 to 14, whatever was written there.
- R7: The key-mask register at word address 1 reads back the value last written. Writes to addresses 2 and 3 change neither register, and reads of those addresses return 0.
- R8: On each sleep rising edge, `key_mask_o` takes the key-mask register value held before that edge. It does not change at any other time, including when the key-mask register is rewritten.
- R9: If a sleep rising edge and a status-clearing write happen on the same clock edge, the sleep status ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe, valid with `bus_sel` |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| guest_sleep_i | input | 1 | Sleep level from the guest, synchronous to `clk` |
| guest_wake_o | output | 1 | One-cycle wake pulse to the guest |
| host_irq_o | output | 1 | Level interrupt to the host |
| key_mask_o | output | 16 | Key-mask snapshot for the input-scanning logic |

## Verification
The assertions assume that `guest_sleep_i` is already synchronous to `clk`. They also assume the bus writes at most one word per cycle, with `bus_wdata` valid whenever `bus_sel` and `bus_we` are high. The bench drives every input on the falling edge and holds it for whole cycles. It raises the sleep input only from a low level, except in the held-level case, which deliberately keeps the input high across several acknowledges. Sleep edges coincide with bus writes only in the deliberate collision case, which covers the set-over-clear priority.

// File: rtl/gsc_pkg.sv
// Shared constants and types for the guest sleep controller.
// Assumes a 16-bit register word; the bit positions are behavioural and fixed.
package gsc_pkg;
    localparam int unsigned WAKE_BIT = 0;
    localparam int unsigned ACK_BIT  = 1;

    // Which register a bus address decodes to.
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/gsc_edge_detect.sv
// Rising-edge detector for the guest sleep level.
// Assumes level_i is already synchronous to clk.
module gsc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

    // R2: a held level yields one rise only
    a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/gsc_sleep_ctrl.sv
// Sleep status, interrupt enable and wake pulse logic.
// Assumes wr_i lasts one cycle per bus write and the bit inputs are valid with it.
// A sleep rise takes priority over a status clear on the same edge.
module gsc_sleep_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wake_bit_i,
    input  logic ack_bit_i,
    input  logic ien_bit_i,
    input  logic sleep_rise_i,
    output logic status_o,
    output logic ien_o,
    output logic wake_o,
    output logic irq_o
);
    logic status_q;
    logic ien_q;
    logic wake_q;
    logic wake_req;

    assign wake_req = wr_i & wake_bit_i & ack_bit_i & status_q;

    // Update the status, enable and wake-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            ien_q    <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            wake_q <= wake_req;
            if (wr_i) ien_q <= ien_bit_i;
            if (sleep_rise_i)         status_q <= 1'b1;
            else if (wr_i && ack_bit_i) status_q <= 1'b0;
        end
    end

    assign status_o = status_q;
    assign ien_o    = ien_q;
    assign wake_o   = wake_q;
    assign irq_o    = status_q & ien_q;

    // R2: status only rises after a sleep edge
    a_r2_set_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> $past(sleep_rise_i));
    // R4: a clear without a competing sleep edge leaves status at 0
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_i && ack_bit_i && !sleep_rise_i) |-> !status_q);
    // R5: a wake pulse needs a paired request on a pending status
    a_r5_wake_paired: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(status_q && wr_i && wake_bit_i && ack_bit_i));
    // R3: clearing the enable drops the interrupt
    a_r3_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_i && !ien_bit_i) |-> !irq_o);
    // R9: a sleep edge always leaves status set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_rise_i |=> status_q);
endmodule

// File: rtl/gsc_key_snap.sv
// Key-mask register and snapshot output.
// Assumes capture_i is a one-cycle strobe. The snapshot takes the register
// value held before the capturing edge.
module gsc_key_snap #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              capture_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] keys_o
);
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] keys_q;

    // Host-writable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (wr_i) mask_q <= wdata_i;
    end

    // Snapshot of the mask taken on a sleep edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         keys_q <= '0;
        else if (capture_i) keys_q <= mask_q;
    end

    assign mask_o = mask_q;
    assign keys_o = keys_q;

    // R8: output changes only on a capture
    a_r8_keys_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture_i) |-> $stable(keys_o));
    // R8: a capture loads the previous register value
    a_r8_keys_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(capture_i) |-> (keys_o == $past(mask_q)));
endmodule

// File: rtl/guest_sleep_ctrl.sv
// Top of the guest sleep and wake controller.
// Decodes the bus into a control/status register and a key-mask register
// and returns combinational read data. Assumes one write per cycle at most.
module guest_sleep_ctrl #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              guest_sleep_i,
    output logic              guest_wake_o,
    output logic              host_irq_o,
    output logic [DATA_W-1:0] key_mask_o
);
    import gsc_pkg::*;

    localparam int unsigned IEN_BIT   = DATA_W - 1;
    localparam int unsigned CTRL_ADDR = 0;
    localparam int unsigned MASK_ADDR = 1;

    reg_sel_e          sel;
    logic              wr_ctrl;
    logic              wr_mask;
    logic              sleep_rise;
    logic              status;
    logic              ien;
    logic [DATA_W-1:0] mask_val;
    logic [DATA_W-1:0] ctrl_rd;

    // Map the bus address to a register.
    always_comb begin
        if (bus_addr == ADDR_W'(CTRL_ADDR))      sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(MASK_ADDR)) sel = SEL_MASK;
        else                                     sel = SEL_NONE;
    end

    assign wr_ctrl = bus_sel & bus_we & (sel == SEL_CTRL);
    assign wr_mask = bus_sel & bus_we & (sel == SEL_MASK);

    gsc_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (guest_sleep_i),
        .rise_o  (sleep_rise)
    );

    gsc_sleep_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_ctrl),
        .wake_bit_i   (bus_wdata[WAKE_BIT]),
        .ack_bit_i    (bus_wdata[ACK_BIT]),
        .ien_bit_i    (bus_wdata[IEN_BIT]),
        .sleep_rise_i (sleep_rise),
        .status_o     (status),
        .ien_o        (ien),
        .wake_o       (guest_wake_o),
        .irq_o        (host_irq_o)
    );

    gsc_key_snap #(.DATA_W(DATA_W)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_mask),
        .wdata_i   (bus_wdata),
        .capture_i (sleep_rise),
        .mask_o    (mask_val),
        .keys_o    (key_mask_o)
    );

    // Assemble the control word: only status and enable are readable.
    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[ACK_BIT] = status;
        ctrl_rd[IEN_BIT] = ien;
    end

    // Select read data for the addressed register.
    always_comb begin
        unique case (sel)
            SEL_CTRL: bus_rdata = ctrl_rd;
            SEL_MASK: bus_rdata = mask_val;
            default:  bus_rdata = '0;
        endcase
    end

    // R6: write-only and unused control bits never read back
    a_r6_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CTRL) |-> (bus_rdata[IEN_BIT-1:ACK_BIT+1] == '0 && !bus_rdata[WAKE_BIT]));
    // R3: interrupt only while status is visible on the bus
    a_r3_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq_o && sel == SEL_CTRL) |-> (bus_rdata[ACK_BIT] && bus_rdata[IEN_BIT]));
endmodule

// File: tb/guest_sleep_ctrl_bench.sv
module guest_sleep_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        guest_sleep_i = 1'b0;
    logic        guest_wake_o;
    logic        host_irq_o;
    logic [15:0] key_mask_o;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    guest_sleep_ctrl u_guest_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .guest_sleep_i(guest_sleep_i), .guest_wake_o(guest_wake_o),
        .host_irq_o(host_irq_o), .key_mask_o(key_mask_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic sleep_pulse();
        @(negedge clk);
        guest_sleep_i = 1'b1;
        @(negedge clk);
        guest_sleep_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(2'd1, v); chk("R1 mask", v, 16'h0000);
        chk("R1 irq", {15'd0, host_irq_o}, 16'd0);
        chk("R1 wake", {15'd0, guest_wake_o}, 16'd0);
        chk("R1 keys", key_mask_o, 16'h0000);

        // R6 walking ones through the control register
        for (int b = 0; b < 16; b++) begin
            wr(2'd0, 16'(1) << b);
            rd(2'd0, v);
            chk("R6/R3 ctrl readback", v, (b == 15) ? 16'h8000 : 16'h0000);
        end
        wr(2'd0, 16'h0000);

        // R7 key-mask readback sweep
        for (int b = 0; b < 16; b++) begin
            wr(2'd1, 16'hA5C3 ^ (16'(1) << b));
            rd(2'd1, v);
            chk("R7 mask readback", v, 16'hA5C3 ^ (16'(1) << b));
        end
        chk("R8 keys untouched by mask writes", key_mask_o, 16'h0000);

        // R7 unmapped addresses
        wr(2'd1, 16'h1234);
        for (int a = 2; a < 4; a++) begin
            wr(2'(a), 16'hFFFF);
            rd(2'(a), v); chk("R7 unmapped read", v, 16'h0000);
            rd(2'd0, v);  chk("R7 ctrl unchanged", v, 16'h0000);
            rd(2'd1, v);  chk("R7 mask unchanged", v, 16'h1234);
        end

        // R2/R8 sleep entry sets status and snapshots mask
        sleep_pulse();
        rd(2'd0, v); chk("R2 status set", v, 16'h0002);
        chk("R8 keys snapshot", key_mask_o, 16'h1234);
        chk("R3 irq off when disabled", {15'd0, host_irq_o}, 16'd0);
        wr(2'd1, 16'h00FF);
        chk("R8 keys hold after mask write", key_mask_o, 16'h1234);
        wr(2'd0, 16'h0002);

        // R4/R5 sweep: pending x {bit0, bit1}
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 4; w++) begin
                wr(2'd0, 16'h0002);
                if (p == 1) sleep_pulse();
                wr(2'd0, 16'(w));
                chk("R5 wake pulse", {15'd0, guest_wake_o}, (p == 1 && w == 3) ? 16'd1 : 16'd0);
                rd(2'd0, v);
                chk("R4 status after write", v, (p == 1 && w < 2) ? 16'h0002 : 16'h0000);
                @(negedge clk);
                chk("R5 pulse one cycle", {15'd0, guest_wake_o}, 16'd0);
            end
        end
        chk("R8 keys from second snapshot", key_mask_o, 16'h00FF);

        // R3 interrupt level
        wr(2'd0, 16'h8000);
        chk("R3 irq low without status", {15'd0, host_irq_o}, 16'd0);
        sleep_pulse();
        chk("R3 irq high", {15'd0, host_irq_o}, 16'd1);
        wr(2'd0, 16'h0000);
        chk("R3 irq drops on enable clear", {15'd0, host_irq_o}, 16'd0);
        rd(2'd0, v); chk("R3 status kept", v, 16'h0002);
        wr(2'd0, 16'h8000);
        chk("R3 irq back on enable", {15'd0, host_irq_o}, 16'd1);
        wr(2'd0, 16'h8002);
        chk("R3 irq drops on ack", {15'd0, host_irq_o}, 16'd0);
        rd(2'd0, v); chk("R3 enable kept", v, 16'h8000);

        // R2 held sleep level sets status only once
        @(negedge clk); guest_sleep_i = 1'b1;
        @(negedge clk);
        wr(2'd0, 16'h0002);
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk("R2 held level no re-set", v, 16'h0000);
        guest_sleep_i = 1'b0;
        sleep_pulse();
        rd(2'd0, v); chk("R2 new episode sets", v, 16'h0002);

        // R9 sleep edge collides with ack
        wr(2'd0, 16'h0002);
        @(negedge clk);
        guest_sleep_i = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0002;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; guest_sleep_i = 1'b0;
        rd(2'd0, v); chk("R9 set wins", v, 16'h0002);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule